// File: doc/BRIEF.md
# Delayed Self-Releasing Processor Reset Sequencer

This block turns one software-writable, active-low control bit into a timed soft reset for a processor subsystem. When software clears the bit, the block first enters a grace phase in which a warning output is raised, so the processor can finish and stop its outstanding bus transfers. A reset that arrives in the middle of a bus transfer could leave the bus hung. After the grace phase the block drives the processor reset low for a fixed number of cycles. It then releases the reset by itself and the processor boots again. Software never has to write the bit a second time.

The two phase lengths are parameters counted in clock cycles. The defaults are 600 grace cycles and 200 hold cycles, which is 24 us and 8 us at 25 MHz. A busy flag is high for the whole sequence, and the control bit reads back 0 while a sequence runs. Writes that arrive while the block is busy are dropped. The reset output comes straight from a flip-flop, so it cannot glitch.

Top module: `cpurst_seq`

## Requirements
- R1: While and right after the block reset, `cpu_rst_n` is 1, `busy` is 0, `pending` is 0 and `ctrl_rd` is 1.
- R2: A cycle with `wr_en`=1 and `wr_data`=0 while `busy` is 0 starts a sequence. From the next cycle on, `busy` and `pending` are 1 and `ctrl_rd` is 0.
- R3: `pending` stays high for exactly GRACE_CYC cycles after the starting write. During those cycles `cpu_rst_n` stays 1.
- R4: In the cycle after the last grace cycle, `cpu_rst_n` goes to 0 and `pending` goes to 0. `cpu_rst_n` stays 0 for exactly HOLD_CYC cycles.
- R5: After the hold phase, `cpu_rst_n` returns to 1, `busy` returns to 0 and `ctrl_rd` reads 1 again, with no further write.
- R6: While `busy` is 1, any write is ignored. This includes a write in the last hold cycle. Such a write neither restarts nor stretches either phase.
- R7: A write of 1 while idle has no effect. All outputs stay at their idle values.
- R8: When `wr_en` is 0, `wr_data` has no effect, even if it is 0.
- R9: `pending` and an active `cpu_rst_n` are never high in the same cycle. `busy` is 1 whenever either of them is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| wr_en | input | 1 | Write strobe for the control bit |
| wr_data | input | 1 | Write data; 0 requests a processor reset |
| ctrl_rd | output | 1 | Read-back value of the control bit (0 while a sequence runs) |
| busy | output | 1 | High for the whole grace and hold sequence |
| pending | output | 1 | Warning to the processor during the grace phase |
| cpu_rst_n | output | 1 | Registered processor reset, active low |

## Verification
Two things can happen in the same cycle: a new request to start, and the end of the hold phase. In that cycle the old sequence is still busy, so the request must be dropped. The cycle after release, however, must accept a new request. To provoke this, the bench holds a reset request on every cycle across two full sequences, so one request lands exactly on the final hold cycle and another on the first idle cycle. A cycle-count reference model judges the result: the second sequence must start one cycle after release, never earlier. Sparse random writes of either value then strike grace, hold and idle cycles, and every output is compared every cycle.

// File: rtl/cpurst_pkg.sv
package cpurst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GRACE = 2'd1,
      ST_HOLD  = 2'd2
   } seq_state_t;

   // Width needed to hold the larger of two cycle counts
   function automatic int unsigned span_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/cpurst_timer.sv
module cpurst_timer #(
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/cpurst_ctrl.sv
module cpurst_ctrl
   import cpurst_pkg::*;
#(
   parameter int unsigned GRACE_CYC = 600,
   parameter int unsigned HOLD_CYC  = 200,
   parameter int unsigned CW        = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          expired,
   output logic          load,
   output logic [CW-1:0] load_val,
   output seq_state_t    state,
   output logic          rst_out_n
);

   localparam logic [CW-1:0] GRACE_LD = CW'(GRACE_CYC - 1);
   localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);

   seq_state_t state_q, state_d;
   logic       rst_out_q;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d  = ST_GRACE;
               load     = 1'b1;
               load_val = GRACE_LD;
            end
         end
         ST_GRACE: begin
            if (expired) begin
               state_d  = ST_HOLD;
               load     = 1'b1;
               load_val = HOLD_LD;
            end
         end
         ST_HOLD: begin
            if (expired) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rst_out_q <= 1'b1;
      end else begin
         state_q   <= state_d;
         rst_out_q <= (state_d != ST_HOLD);
      end
   end

   assign state     = state_q;
   assign rst_out_n = rst_out_q;

endmodule

// File: rtl/cpurst_seq.sv
module cpurst_seq
   import cpurst_pkg::*;
#(
   parameter int unsigned GRACE_CYC = 600,
   parameter int unsigned HOLD_CYC  = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_data,
   output logic ctrl_rd,
   output logic busy,
   output logic pending,
   output logic cpu_rst_n
);

   localparam int unsigned CW = span_width(GRACE_CYC, HOLD_CYC);

   if (GRACE_CYC < 1) begin : g_bad_grace
      $error("cpurst_seq: GRACE_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("cpurst_seq: HOLD_CYC must be at least 1");
   end

   seq_state_t    state;
   logic          load;
   logic [CW-1:0] load_val;
   logic          expired;
   logic          start;

   assign start = wr_en && !wr_data && (state == ST_IDLE);

   cpurst_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   cpurst_ctrl #(
      .GRACE_CYC (GRACE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .CW        (CW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .expired   (expired),
      .load      (load),
      .load_val  (load_val),
      .state     (state),
      .rst_out_n (cpu_rst_n)
   );

   assign pending = (state == ST_GRACE);
   assign busy    = (state != ST_IDLE);
   assign ctrl_rd = (state == ST_IDLE);

endmodule

// File: rtl/cpurst_seq_chk.sv
module cpurst_seq_chk #(
   parameter int unsigned GRACE_CYC = 600,
   parameter int unsigned HOLD_CYC  = 200
) (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic wr_data,
   input logic ctrl_rd,
   input logic busy,
   input logic pending,
   input logic cpu_rst_n
);

   localparam int unsigned LW = $clog2(((GRACE_CYC > HOLD_CYC) ? GRACE_CYC : HOLD_CYC) + 2);

   logic [LW-1:0] pend_len, hold_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_len <= '0;
         hold_len <= '0;
      end else begin
         pend_len <= pending    ? pend_len + 1'b1 : '0;
         hold_len <= !cpu_rst_n ? hold_len + 1'b1 : '0;
      end
   end

   p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cpu_rst_n && !pending && ctrl_rd));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && !wr_data) |=> (busy && pending && !ctrl_rd));

   p_grace_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> (pend_len == LW'(GRACE_CYC)));

   p_hold_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> !cpu_rst_n);

   p_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> (hold_len == LW'(HOLD_CYC)));

   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> (!busy && ctrl_rd));

   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst_n |=> !pending);

   p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(wr_en && !wr_data)) |=> !busy);

   p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pending && !cpu_rst_n));

   p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pending || !cpu_rst_n) |-> busy);

endmodule

bind cpurst_seq cpurst_seq_chk #(
   .GRACE_CYC (GRACE_CYC),
   .HOLD_CYC  (HOLD_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .ctrl_rd   (ctrl_rd),
   .busy      (busy),
   .pending   (pending),
   .cpu_rst_n (cpu_rst_n)
);

// File: tb/cpurst_seq_bench.sv
`timescale 1ns/1ps
module cpurst_seq_bench;

   localparam int unsigned G = 600;
   localparam int unsigned H = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_data = 1'b1;
   logic ctrl_rd, busy, pending, cpu_rst_n;

   int checks = 0;
   int fails = 0;

   // reference model: cycles elapsed since the starting edge
   bit m_active = 1'b0;
   int m_age = 0;

   always #2.5 clk = ~clk;

   cpurst_seq #(.GRACE_CYC(G), .HOLD_CYC(H)) u_cpurst_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .ctrl_rd   (ctrl_rd),
      .busy      (busy),
      .pending   (pending),
      .cpu_rst_n (cpu_rst_n)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 1'b0;
         m_age    = 0;
      end else if (m_active) begin
         m_age = m_age + 1;
         if (m_age == int'(G + H)) m_active = 1'b0;
      end else if (wr_en && !wr_data) begin
         m_active = 1'b1;
         m_age    = 0;
      end
   end

   function automatic logic exp_pending();
      return m_active && (m_age < int'(G));
   endfunction

   function automatic logic exp_rst_n();
      return !(m_active && (m_age >= int'(G)));
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(pending,   exp_pending(), "R3 pending");
      chk(cpu_rst_n, exp_rst_n(),   "R4 cpu_rst_n");
      chk(busy,      m_active,      "R6 busy");
      chk(ctrl_rd,   !m_active,     "R5 ctrl_rd");
      chk(!(pending && !cpu_rst_n), 1'b1, "R9 exclusive");
   endtask

   task automatic step(input logic en, input logic d);
      @(negedge clk);
      compare_all();
      wr_en   = en;
      wr_data = d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(cpu_rst_n, 1'b1, "R1 cpu_rst_n in reset");
      chk(busy,      1'b0, "R1 busy in reset");
      chk(pending,   1'b0, "R1 pending in reset");
      chk(ctrl_rd,   1'b1, "R1 ctrl_rd in reset");
      rst_n = 1'b1;
      step(0, 1);
      step(0, 1);
      chk(busy, 1'b0, "R1 busy after reset");

      // R7: write of 1 while idle
      step(1, 1);
      step(0, 0);
      chk(busy, 1'b0, "R7 busy after write 1");
      chk(ctrl_rd, 1'b1, "R7 ctrl_rd after write 1");

      // R8: data 0 without strobe
      step(0, 0);
      chk(busy, 1'b0, "R8 busy after unstrobed 0");
      chk(pending, 1'b0, "R8 pending after unstrobed 0");

      // R2..R5: single clean sequence
      step(1, 0);
      step(0, 1);
      chk(busy && pending, 1'b1, "R2 start");
      chk(ctrl_rd, 1'b0, "R2 ctrl_rd during sequence");
      for (int i = 0; i < int'(G + H) + 4; i++) step(0, 1);
      chk(cpu_rst_n && ctrl_rd && !busy, 1'b1, "R5 self release");

      // R6: request held every cycle across two sequences
      for (int i = 0; i < 2 * int'(G + H) + 6; i++) step(1, 0);
      for (int i = 0; i < int'(G + H) + 4; i++) step(0, 1);

      // random mix of sparse writes of either value
      for (int i = 0; i < 30000; i++) begin
         step(($urandom % 40) == 0, $urandom % 2);
      end
      for (int i = 0; i < int'(G + H) + 4; i++) step(0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule